// File: doc/BRIEF.md
# Register Rename Table with In-Order Retirement and Precise Rollback

This block gives an out-of-order core its register renaming together with in-order retirement. It keeps one table for the architectural registers. Each entry there holds a committed value, a flag that marks the register as waiting on an in-flight producer, and the tag of the latest producer. A circular pool of physical registers is handed out one entry per issued instruction, in program order. Each pool entry holds busy, valid and fault bits, the result, the PC of the producing instruction and its architectural destination. The pool is also the reorder buffer.

Execution units report results, and any fault, through a completion port. The block retires the oldest entry once it is done. A clean result is copied into the committed value of its destination. A faulting result is never copied. Instead the block raises an exception with the faulting PC, empties the pool and clears every waiting flag, so the register file falls back to the committed values. Younger results that finished early are discarded along with the rest. Operand lookups return a producer tag while a register is waiting, and the committed value otherwise.

Top module: `rnm_core`

## Requirements
- R1: After reset the pool is empty and `ren_ready` is 1. No commit and no exception is signalled. Every architectural register reads as not waiting with committed value 0.
- R2: Each accepted rename (`ren_valid` and `ren_ready` both 1) returns on `ren_tag` the tag of the pool entry it takes. Tags start at 0 after reset, rise by 1 per accepted rename and wrap modulo the pool depth. A lookup of the destination then returns waiting=1 with that tag.
- R3: The pool holds at most depth-1 live entries. At that occupancy `ren_ready` is 0, and a rename presented then takes no tag.
- R4: A completed entry that is not the oldest live entry is not committed. The committed value and the waiting flag of its destination stay unchanged until every older entry has retired.
- R5: When the oldest live entry has completed without a fault, `cmt_valid` is 1 with its destination on `cmt_areg` and its result on `cmt_value`. At the next clock edge the result becomes the committed value and the entry is freed. At most one entry retires per cycle.
- R6: Retiring an entry clears the waiting flag of its destination only when no younger in-flight entry writes that register. Otherwise the register stays waiting with the younger tag.
- R7: When the oldest live entry completed with its fault bit set, `exc_valid` is 1 and `exc_pc` carries that entry's PC, while `cmt_valid` is 0. The faulting result never reaches a committed value.
- R8: One clock edge after `exc_valid`, all pool entries are free, `ren_ready` is 1, and every register reads as not waiting with its committed value. The next rename receives the tag of the faulting entry.
- R9: A completion that names a pool entry which is not busy is ignored. If that entry is later allocated, it starts as not complete.
- R10: A lookup of a register that is not waiting returns the register's committed value on `lk_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | Rename request |
| ren_ready | output | 1 | Pool can accept a rename this cycle |
| ren_dst | input | AREG_W | Architectural destination of the renamed instruction |
| ren_pc | input | PC_W | PC of the renamed instruction |
| ren_tag | output | TAG_W | Pool tag given to the renamed instruction |
| lk_areg | input | NUM_SRC*AREG_W | Source registers to look up; slot k in bits [k*AREG_W +: AREG_W] |
| lk_wait | output | NUM_SRC | Per slot: the register has an in-flight producer |
| lk_tag | output | NUM_SRC*TAG_W | Per slot: tag of the latest producer |
| lk_value | output | NUM_SRC*DATA_W | Per slot: committed value of the register |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Pool tag of the completing instruction |
| cmp_value | input | DATA_W | Result value |
| cmp_fault | input | 1 | Instruction raised a fault in its first execute cycle |
| cmt_valid | output | 1 | Oldest entry retires at the next edge |
| cmt_areg | output | AREG_W | Destination of the retiring entry |
| cmt_value | output | DATA_W | Result of the retiring entry |
| exc_valid | output | 1 | Oldest entry faulted; flush at the next edge |
| exc_pc | output | PC_W | PC of the faulting entry |

## Verification
A wrong head pointer or a stale valid bit shows up in the same cycle as `cmt_valid` or `exc_valid` rising too early, or carrying the wrong destination or value. A younger result that slips past an older fault shows up at the next edge, as a changed committed value on a lookup. A waiting flag that is cleared too soon shows up right after the older writer retires, on the lookup of a register that has two producers. A tail pointer that is wrong after a flush shows up on the very next rename, as an unexpected `ren_tag`.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

   // outcome of the oldest pool entry in a given cycle
   typedef enum logic [1:0] {
      RT_NONE   = 2'd0,
      RT_COMMIT = 2'd1,
      RT_TRAP   = 2'd2
   } rnm_retire_e;

   typedef struct packed {
      logic busy;
      logic valid;
      logic fault;
   } rnm_flags_t;

endpackage

// File: rtl/rnm_pool.sv
module rnm_pool
   import rnm_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int PC_W   = 16,
   parameter int AREG_W = 3,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [AREG_W-1:0] alloc_areg,
   input  logic [PC_W-1:0]   alloc_pc,
   input  logic              cmp_en,
   input  logic [TAG_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic              cmp_fault,
   output logic [TAG_W-1:0]  tail_o,
   output logic [TAG_W-1:0]  head_o,
   output logic              full_o,
   output rnm_retire_e       retire_o,
   output logic [AREG_W-1:0] head_areg_o,
   output logic [DATA_W-1:0] head_value_o,
   output logic [PC_W-1:0]   head_pc_o
);

   logic [TAG_W-1:0] head_q, tail_q;
   rnm_flags_t [DEPTH-1:0]               flg_v;
   logic       [DEPTH-1:0][DATA_W-1:0]   val_v;
   logic       [DEPTH-1:0][PC_W-1:0]     pc_v;
   logic       [DEPTH-1:0][AREG_W-1:0]   areg_v;
   rnm_flags_t hd_flg;
   logic       do_commit, do_trap;

   assign hd_flg    = flg_v[head_q];
   assign do_commit = hd_flg.busy & hd_flg.valid & ~hd_flg.fault;
   assign do_trap   = hd_flg.busy & hd_flg.valid &  hd_flg.fault;

   always_comb begin
      retire_o = RT_NONE;
      if (do_commit)    retire_o = RT_COMMIT;
      else if (do_trap) retire_o = RT_TRAP;
   end

   assign tail_o       = tail_q;
   assign head_o       = head_q;
   assign full_o       = (tail_q + TAG_W'(1)) == head_q;
   assign head_areg_o  = areg_v[head_q];
   assign head_value_o = val_v[head_q];
   assign head_pc_o    = pc_v[head_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (do_trap) begin
         tail_q <= head_q;
      end else begin
         if (alloc_en)  tail_q <= tail_q + TAG_W'(1);
         if (do_commit) head_q <= head_q + TAG_W'(1);
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic [TAG_W-1:0] IDX = TAG_W'(e);
      rnm_flags_t        flg_q;
      logic [DATA_W-1:0] val_q;
      logic [PC_W-1:0]   pc_q;
      logic [AREG_W-1:0] areg_q;
      logic              hit_cmp;

      assign hit_cmp = cmp_en && (cmp_tag == IDX) && flg_q.busy;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flg_q <= '0;
         end else if (do_trap) begin
            flg_q <= '0;
         end else if (alloc_en && tail_q == IDX) begin
            flg_q <= '{busy: 1'b1, valid: 1'b0, fault: 1'b0};
         end else if (do_commit && head_q == IDX) begin
            flg_q <= '0;
         end else if (hit_cmp) begin
            flg_q.valid <= 1'b1;
            flg_q.fault <= cmp_fault;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            pc_q   <= '0;
            areg_q <= '0;
         end else begin
            if (alloc_en && tail_q == IDX && !do_trap) begin
               pc_q   <= alloc_pc;
               areg_q <= alloc_areg;
            end
            if (hit_cmp && !do_trap) val_q <= cmp_value;
         end
      end

      assign flg_v[e]  = flg_q;
      assign val_v[e]  = val_q;
      assign pc_v[e]   = pc_q;
      assign areg_v[e] = areg_q;
   end

endmodule

// File: rtl/rnm_archtab.sv
module rnm_archtab #(
   parameter int NUM_ARCH = 8,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 3,
   localparam int AREG_W  = $clog2(NUM_ARCH)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             alloc_en,
   input  logic [AREG_W-1:0]                alloc_areg,
   input  logic [TAG_W-1:0]                 alloc_tag,
   input  logic                             commit_en,
   input  logic [AREG_W-1:0]                commit_areg,
   input  logic [TAG_W-1:0]                 commit_tag,
   input  logic [DATA_W-1:0]                commit_value,
   input  logic                             flush,
   output logic [NUM_ARCH-1:0]              wait_o,
   output logic [NUM_ARCH-1:0][TAG_W-1:0]   map_o,
   output logic [NUM_ARCH-1:0][DATA_W-1:0]  rest_o
);

   for (genvar r = 0; r < NUM_ARCH; r++) begin : g_reg
      localparam logic [AREG_W-1:0] ID = AREG_W'(r);
      logic              wait_q;
      logic [TAG_W-1:0]  map_q;
      logic [DATA_W-1:0] rest_q;
      logic              own_commit;

      assign own_commit = commit_en && (commit_areg == ID);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wait_q <= 1'b0;
            map_q  <= '0;
         end else if (flush) begin
            wait_q <= 1'b0;
         end else if (alloc_en && alloc_areg == ID) begin
            wait_q <= 1'b1;
            map_q  <= alloc_tag;
         end else if (own_commit && map_q == commit_tag) begin
            wait_q <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          rest_q <= '0;
         else if (own_commit) rest_q <= commit_value;
      end

      assign wait_o[r] = wait_q;
      assign map_o[r]  = map_q;
      assign rest_o[r] = rest_q;
   end

endmodule

// File: rtl/rnm_lookup.sv
module rnm_lookup #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_SRC  = 2,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 3,
   localparam int AREG_W  = $clog2(NUM_ARCH)
) (
   input  logic [NUM_SRC*AREG_W-1:0]        areg_i,
   input  logic [NUM_ARCH-1:0]              wait_i,
   input  logic [NUM_ARCH-1:0][TAG_W-1:0]   map_i,
   input  logic [NUM_ARCH-1:0][DATA_W-1:0]  rest_i,
   output logic [NUM_SRC-1:0]               wait_o,
   output logic [NUM_SRC*TAG_W-1:0]         tag_o,
   output logic [NUM_SRC*DATA_W-1:0]        value_o
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [AREG_W-1:0] sel;
      assign sel                         = areg_i[s*AREG_W +: AREG_W];
      assign wait_o[s]                   = wait_i[sel];
      assign tag_o[s*TAG_W +: TAG_W]     = map_i[sel];
      assign value_o[s*DATA_W +: DATA_W] = rest_i[sel];
   end

endmodule

// File: rtl/rnm_core.sv
module rnm_core
   import rnm_pkg::*;
#(
   parameter int POOL_DEPTH = 8,
   parameter int NUM_ARCH   = 8,
   parameter int NUM_SRC    = 2,
   parameter int DATA_W     = 32,
   parameter int PC_W       = 16,
   localparam int TAG_W     = $clog2(POOL_DEPTH),
   localparam int AREG_W    = $clog2(NUM_ARCH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ren_valid,
   output logic                      ren_ready,
   input  logic [AREG_W-1:0]         ren_dst,
   input  logic [PC_W-1:0]           ren_pc,
   output logic [TAG_W-1:0]          ren_tag,
   input  logic [NUM_SRC*AREG_W-1:0] lk_areg,
   output logic [NUM_SRC-1:0]        lk_wait,
   output logic [NUM_SRC*TAG_W-1:0]  lk_tag,
   output logic [NUM_SRC*DATA_W-1:0] lk_value,
   input  logic                      cmp_valid,
   input  logic [TAG_W-1:0]          cmp_tag,
   input  logic [DATA_W-1:0]         cmp_value,
   input  logic                      cmp_fault,
   output logic                      cmt_valid,
   output logic [AREG_W-1:0]         cmt_areg,
   output logic [DATA_W-1:0]         cmt_value,
   output logic                      exc_valid,
   output logic [PC_W-1:0]           exc_pc
);

   initial begin
      assert (POOL_DEPTH >= 4 && (1 << TAG_W) == POOL_DEPTH)
         else $fatal(1, "POOL_DEPTH must be a power of two, at least 4");
      assert (NUM_ARCH >= 2 && (1 << AREG_W) == NUM_ARCH)
         else $fatal(1, "NUM_ARCH must be a power of two, at least 2");
      assert (NUM_SRC >= 1 && DATA_W >= 1 && PC_W >= 1)
         else $fatal(1, "NUM_SRC, DATA_W and PC_W must be positive");
   end

   logic [TAG_W-1:0]  tail, head;
   logic              full, alloc_en;
   rnm_retire_e       retire;
   logic [AREG_W-1:0] hd_areg;
   logic [DATA_W-1:0] hd_value;
   logic [PC_W-1:0]   hd_pc;
   logic [NUM_ARCH-1:0]             a_wait;
   logic [NUM_ARCH-1:0][TAG_W-1:0]  a_map;
   logic [NUM_ARCH-1:0][DATA_W-1:0] a_rest;

   assign exc_valid = (retire == RT_TRAP);
   assign cmt_valid = (retire == RT_COMMIT);
   assign ren_ready = ~full & ~exc_valid;
   assign alloc_en  = ren_valid & ren_ready;
   assign ren_tag   = tail;
   assign cmt_areg  = hd_areg;
   assign cmt_value = hd_value;
   assign exc_pc    = hd_pc;

   rnm_pool #(
      .DEPTH(POOL_DEPTH), .DATA_W(DATA_W), .PC_W(PC_W), .AREG_W(AREG_W)
   ) u_pool (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_areg(ren_dst), .alloc_pc(ren_pc),
      .cmp_en(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
      .cmp_fault(cmp_fault),
      .tail_o(tail), .head_o(head), .full_o(full), .retire_o(retire),
      .head_areg_o(hd_areg), .head_value_o(hd_value), .head_pc_o(hd_pc)
   );

   rnm_archtab #(
      .NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .TAG_W(TAG_W)
   ) u_arch (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_areg(ren_dst), .alloc_tag(tail),
      .commit_en(cmt_valid), .commit_areg(hd_areg), .commit_tag(head),
      .commit_value(hd_value), .flush(exc_valid),
      .wait_o(a_wait), .map_o(a_map), .rest_o(a_rest)
   );

   rnm_lookup #(
      .NUM_ARCH(NUM_ARCH), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .TAG_W(TAG_W)
   ) u_look (
      .areg_i(lk_areg), .wait_i(a_wait), .map_i(a_map), .rest_i(a_rest),
      .wait_o(lk_wait), .tag_o(lk_tag), .value_o(lk_value)
   );

endmodule

// File: rtl/rnm_chk.sv
module rnm_chk #(
   parameter int DEPTH   = 8,
   parameter int NUM_SRC = 2,
   localparam int TAG_W  = $clog2(DEPTH)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ren_valid,
   input logic               ren_ready,
   input logic [TAG_W-1:0]   ren_tag,
   input logic               cmt_valid,
   input logic               exc_valid,
   input logic [NUM_SRC-1:0] lk_wait
);

   logic [TAG_W:0]   occ_q;
   logic [TAG_W-1:0] last_q;
   logic             seen_q;
   logic             acc;

   assign acc = ren_valid & ren_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q  <= '0;
         last_q <= '0;
         seen_q <= 1'b0;
      end else if (exc_valid) begin
         occ_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         occ_q <= occ_q + (TAG_W+1)'(acc) - (TAG_W+1)'(cmt_valid);
         if (acc) begin
            last_q <= ren_tag;
            seen_q <= 1'b1;
         end
      end
   end

   AST_READY_VS_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (ren_ready == (occ_q < (TAG_W+1)'(DEPTH - 1)))); // R3
   AST_TAG_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && seen_q) |-> (ren_tag == last_q + TAG_W'(1))); // R2
   AST_RETIRE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmt_valid && exc_valid)); // R7
   AST_READY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> ren_ready); // R8
   AST_WAIT_CLEAR_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (lk_wait == '0)); // R8
   AST_EMPTY_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q == '0) |-> !(cmt_valid || exc_valid)); // R1

endmodule

bind rnm_core rnm_chk #(.DEPTH(POOL_DEPTH), .NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
   .ren_tag(ren_tag), .cmt_valid(cmt_valid), .exc_valid(exc_valid),
   .lk_wait(lk_wait)
);

// File: tb/rnm_core_bench.sv
module rnm_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8, NARCH = 8, NSRC = 2, DW = 32, PW = 16;
   localparam int TW = $clog2(DEPTH), AW = $clog2(NARCH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic ren_valid = 1'b0, ren_ready;
   logic [AW-1:0] ren_dst = '0;
   logic [PW-1:0] ren_pc = '0;
   logic [TW-1:0] ren_tag;
   logic [NSRC*AW-1:0] lk_areg = '0;
   logic [NSRC-1:0] lk_wait;
   logic [NSRC*TW-1:0] lk_tag;
   logic [NSRC*DW-1:0] lk_value;
   logic cmp_valid = 1'b0, cmp_fault = 1'b0;
   logic [TW-1:0] cmp_tag = '0;
   logic [DW-1:0] cmp_value = '0;
   logic cmt_valid, exc_valid;
   logic [AW-1:0] cmt_areg;
   logic [DW-1:0] cmt_value;
   logic [PW-1:0] exc_pc;

   int total = 0, bad = 0;
   int exp_tail = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rnm_core #(.POOL_DEPTH(DEPTH), .NUM_ARCH(NARCH), .NUM_SRC(NSRC),
              .DATA_W(DW), .PC_W(PW)) u_rnm_core (
      .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
      .ren_dst(ren_dst), .ren_pc(ren_pc), .ren_tag(ren_tag), .lk_areg(lk_areg),
      .lk_wait(lk_wait), .lk_tag(lk_tag), .lk_value(lk_value),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
      .cmp_fault(cmp_fault), .cmt_valid(cmt_valid), .cmt_areg(cmt_areg),
      .cmt_value(cmt_value), .exc_valid(exc_valid), .exc_pc(exc_pc)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk); #1;
   endtask

   task automatic look(input int r, input bit ew, input int et, input longint ev, input string req);
      lk_areg[AW-1:0] = AW'(r);
      #1;
      chk(lk_wait[0] == ew, {req, " wait"}, lk_wait[0], ew);
      if (ew) chk(lk_tag[TW-1:0] == TW'(et), {req, " tag"}, lk_tag[TW-1:0], et);
      else    chk(lk_value[DW-1:0] == DW'(ev), {req, " value"}, lk_value[DW-1:0], ev);
   endtask

   task automatic ren(input int dst, input int pc);
      ren_valid = 1'b1; ren_dst = AW'(dst); ren_pc = PW'(pc);
      #1;
      chk(ren_ready == 1'b1, "R2 ready", ren_ready, 1);
      chk(ren_tag == TW'(exp_tail), "R2 tag", ren_tag, exp_tail);
      tick();
      ren_valid = 1'b0;
      exp_tail = (exp_tail + 1) % DEPTH;
   endtask

   task automatic cmp(input int tag, input longint val, input bit flt);
      cmp_valid = 1'b1; cmp_tag = TW'(tag); cmp_value = DW'(val); cmp_fault = flt;
      tick();
      cmp_valid = 1'b0; cmp_fault = 1'b0;
   endtask

   task automatic see_commit(input int areg, input longint val, input string req);
      chk(cmt_valid == 1'b1, {req, " cmt_valid"}, cmt_valid, 1);
      chk(cmt_areg == AW'(areg), {req, " cmt_areg"}, cmt_areg, areg);
      chk(cmt_value == DW'(val), {req, " cmt_value"}, cmt_value, val);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      longint c_val, g_val;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state, swept over every architectural register
      chk(ren_ready == 1'b1, "R1 ready", ren_ready, 1);
      chk(!cmt_valid && !exc_valid, "R1 quiet", {cmt_valid, exc_valid}, 0);
      for (int r = 0; r < NARCH; r++) look(r, 0, 0, 0, "R1");

      // preload committed values: register r holds r*0x11 for r=1..5
      for (int r = 1; r <= 5; r++) ren(r, 16'h0100 + r);
      for (int k = 0; k < 5; k++) begin
         cmp(k, (k + 1) * 32'h11, 1'b0);
         see_commit(k + 1, (k + 1) * 32'h11, "R5");
      end
      tick();
      for (int r = 1; r <= 5; r++) look(r, 0, 0, r * 32'h11, "R10");

      // multiply r3, divide r5, add r4, subtract r2 (tags 5,6,7,0: wraps)
      c_val = 32'h11 * 32'h22;
      g_val = 32'h22 - 32'h11;
      ren(3, 16'h1001);
      ren(5, 16'h1002);
      ren(4, 16'h1003);
      ren(2, 16'h1004);
      look(2, 1, 0, 0, "R2 sub dst");
      cmp(0, g_val, 1'b0);                     // subtract finishes first
      chk(cmt_valid == 1'b0, "R4 young done", cmt_valid, 0);
      look(2, 1, 0, 0, "R4 sub dst still waiting");
      cmp(5, c_val, 1'b0);                     // multiply finishes
      see_commit(3, c_val, "R5 mul");
      look(3, 1, 5, 0, "R4 mul before retire");
      cmp(6, 32'hDEAD, 1'b1);                  // divide faults; mul retires
      chk(exc_valid == 1'b1, "R7 exc_valid", exc_valid, 1);
      chk(exc_pc == 16'h1002, "R7 exc_pc", exc_pc, 16'h1002);
      chk(cmt_valid == 1'b0, "R7 no commit", cmt_valid, 0);
      look(3, 0, 0, c_val, "R6 mul retired");
      tick();                                  // flush
      chk(exc_valid == 1'b0, "R8 exc drop", exc_valid, 0);
      chk(ren_ready == 1'b1, "R8 ready", ren_ready, 1);
      look(1, 0, 0, 32'h11, "R8 r1");
      look(2, 0, 0, 32'h22, "R8 r2");
      look(3, 0, 0, c_val,  "R8 r3");
      look(4, 0, 0, 32'h44, "R8 r4");
      look(5, 0, 0, 32'h55, "R7 r5 untouched");
      exp_tail = 6;                            // tag of the faulting divide

      // fill the pool: 7 entries, destinations k%4 (tags 6,7,0..4)
      for (int k = 0; k < DEPTH - 1; k++) ren(k % 4, 16'h2000 + k);
      ren_valid = 1'b1; ren_dst = 3'd7;
      #1;
      chk(ren_ready == 1'b0, "R3 full", ren_ready, 0);
      tick();
      ren_valid = 1'b0;
      look(0, 1, 2, 0, "R6 latest writer tag");
      for (int k = DEPTH - 2; k >= 1; k--) begin
         cmp((6 + k) % DEPTH, 32'h100 * k + 7, 1'b0);
         chk(cmt_valid == 1'b0, "R4 head pending", cmt_valid, 0);
      end
      cmp(6, 32'h7, 1'b0);
      for (int k = 0; k < DEPTH - 1; k++) begin
         see_commit(k % 4, 32'h100 * k + 7, "R5 in order");
         tick();
         if (k == 0) look(0, 1, 2, 0, "R6 older retired");
      end
      chk(cmt_valid == 1'b0, "R5 drained", cmt_valid, 0);
      for (int r = 0; r < 4; r++)
         look(r, 0, 0, 32'h100 * (r < 3 ? r + 4 : r) + 7, "R10 after drain");

      // completion to a free entry is ignored (next tag 5)
      cmp(exp_tail, 32'hBAD, 1'b0);
      ren(7, 16'h3000);
      tick();
      chk(cmt_valid == 1'b0, "R9 stale completion", cmt_valid, 0);
      look(7, 1, 5, 0, "R9 still waiting");
      cmp(5, 32'hABC, 1'b0);
      see_commit(7, 32'hABC, "R9 real completion");
      tick();
      look(7, 0, 0, 32'hABC, "R10 r7");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule